// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Force

This block sits between a PWM time-base counter and the output pins. Every clock it receives four event strobes: the counter reached zero, the counter reached the period value, and the up-counting counter matched compare A or compare B. Two control registers, one for each output (A and B), hold a 2-bit action for each of those events. The action can leave the pin alone, drive it low, drive it high or toggle it. Each output pin is a register that updates on the clock edge that samples the events.

A continuous force register sits on top of the event actions. It can hold either pin at a static low or high level. Software writes a shadow copy of it. The copy that actually drives the pins is loaded from the shadow at a point chosen by a reload-select field: on the zero event, on the period event, on either of them, or immediately. The immediate setting lets software pin an output at a fixed level on the next clock, for example to disable it cleanly.

Register writes use a plain single-cycle write strobe with a 2-bit address. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_action_qualifier`

## Requirements
- R1: An action code of 0 leaves the pin unchanged, 1 drives it low, 2 drives it high and 3 inverts it. The new level appears on the clock edge that samples the event.
- R2: In each output's control register, bits [1:0] hold the zero-event action, bits [3:2] the period-event action, bits [5:4] the compare-A up-match action and bits [9:8] the compare-B up-match action. Both outputs respond to both compare events.
- R3: When several strobed events have a non-zero action in the same cycle, one of them decides. Compare A wins over compare B, compare B wins over period, and period wins over zero. A strobed event whose field is 0 has no effect on the pin.
- R4: In the active force value, bits [1:0] apply to output A and bits [3:2] to output B. Code 1 forces the pin low and code 2 forces it high; codes 0 and 3 apply no force. While a force is applied, the pin stays at the forced level whatever events arrive.
- R5: Reload-select bits [7:6] choose when the active force value is copied from the shadow: 0 on a zero event, 1 on a period event, 2 on either event, 3 every cycle. Outside its reload point the active force value does not change, even after the shadow is written.
- R6: With reload select 3, a force-shadow write becomes active on the same edge. The forced level therefore appears on the pin at the next clock edge.
- R7: After reset both pins are low, all action fields are 0, the force shadow and active force are 0, and reload select is 0.
- R8: A write with address 0 loads the output-A control register, 1 loads output B's, 2 loads reload select from data bits [7:6], and 3 loads the force shadow from data bits [3:0]. A written control value governs events from the next cycle on.
- R9: With the normal-polarity setup (A: high at zero and at period, low on the compare-A match) and the inverted setup on B using compare B, counting 0..P with compare C gives A high exactly after counts below C and after count P, and B the complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_zero_i | input | 1 | Counter-equals-zero strobe |
| ev_period_i | input | 1 | Counter-equals-period strobe |
| ev_cmpa_up_i | input | 1 | Up-count match with compare A |
| ev_cmpb_up_i | input | 1 | Up-count match with compare B |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 ctrl A, 1 ctrl B, 2 reload select, 3 force shadow |
| wr_data_i | input | REG_W | Write data |
| pwm_a_o | output | 1 | Output A pin level |
| pwm_b_o | output | 1 | Output B pin level |

## Verification
The assertions assume that each event strobe lasts a single clock and is sampled on that edge. They also assume that reset is applied before any strobe or write. Beyond that, any mix of coincident events and writes is legal, so the properties do not exclude overlap. The stimulus changes inputs only half a cycle away from the sampling edge. It sweeps every combination of action fields against all sixteen event patterns, including events that coincide with force writes and reload-point changes. A counting sequence built from strobes that a real counter would produce checks the polarity patterns.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'd0,
    RLD_PERIOD = 2'd1,
    RLD_EITHER = 2'd2,
    RLD_NOW    = 2'd3
  } rld_e;

  typedef struct packed {
    act_e on_cmpb;
    act_e on_cmpa;
    act_e on_prd;
    act_e on_zro;
  } aq_ctl_t;

  localparam int  NUM_CH     = 2;
  localparam int  FRC_W      = 2 * NUM_CH;
  localparam logic [1:0] ADR_CTL_A = 2'd0;
  localparam logic [1:0] ADR_CTL_B = 2'd1;
  localparam logic [1:0] ADR_RLD   = 2'd2;
  localparam logic [1:0] ADR_FRC   = 2'd3;

  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/aq_event_pick.sv
module aq_event_pick
  import pwm_aq_pkg::*;
(
  input  aq_ctl_t ctl_i,
  input  logic    ev_zero_i,
  input  logic    ev_period_i,
  input  logic    ev_cmpa_i,
  input  logic    ev_cmpb_i,
  output act_e    act_o
);
  // Priority: compare A, compare B, period, zero; empty fields fall through.
  always_comb begin
    act_o = ACT_NONE;
    if (ev_zero_i && ctl_i.on_zro != ACT_NONE)    act_o = ctl_i.on_zro;
    if (ev_period_i && ctl_i.on_prd != ACT_NONE)  act_o = ctl_i.on_prd;
    if (ev_cmpb_i && ctl_i.on_cmpb != ACT_NONE)   act_o = ctl_i.on_cmpb;
    if (ev_cmpa_i && ctl_i.on_cmpa != ACT_NONE)   act_o = ctl_i.on_cmpa;
  end
endmodule

// File: rtl/aq_force_shadow.sv
module aq_force_shadow
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_rld_i,
  input  logic             wr_frc_i,
  input  logic [1:0]       rld_data_i,
  input  logic [FRC_W-1:0] frc_data_i,
  input  logic             ev_zero_i,
  input  logic             ev_period_i,
  output logic [FRC_W-1:0] frc_act_o
);
  rld_e             rld_q;
  logic [FRC_W-1:0] shadow_q;
  logic [FRC_W-1:0] shadow_d;
  logic             load_pt;

  assign shadow_d = wr_frc_i ? frc_data_i : shadow_q;

  always_comb begin
    case (rld_q)
      RLD_ZERO:   load_pt = ev_zero_i;
      RLD_PERIOD: load_pt = ev_period_i;
      RLD_EITHER: load_pt = ev_zero_i | ev_period_i;
      default:    load_pt = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q     <= RLD_ZERO;
      shadow_q  <= '0;
      frc_act_o <= '0;
    end else begin
      if (wr_rld_i) rld_q <= rld_e'(rld_data_i);
      shadow_q <= shadow_d;
      if (rld_q == RLD_NOW)  frc_act_o <= shadow_d;
      else if (load_pt)      frc_act_o <= shadow_q;
    end
  end

  // R6: immediate mode takes a force write on the same edge
  p_now_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_frc_i && rld_q == RLD_NOW) |=> (frc_act_o == $past(frc_data_i)));

  // R5: outside its reload point the active force value is held
  p_hold_off_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_q == RLD_ZERO && !ev_zero_i) |=> $stable(frc_act_o));

  p_hold_prd_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_q == RLD_PERIOD && !ev_period_i) |=> $stable(frc_act_o));
endmodule

// File: rtl/aq_channel_out.sv
module aq_channel_out
  import pwm_aq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  act_e       act_i,
  input  logic [1:0] frc_i,
  output logic       pin_o
);
  logic forced;
  assign forced = (frc_i == 2'd1) || (frc_i == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_o <= 1'b0;
    else if (forced) pin_o <= frc_i[1];
    else             pin_o <= apply_act(act_i, pin_o);
  end

  // R4: forced levels win over every event action
  p_force_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_i == 2'd1) |=> !pin_o);

  p_force_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_i == 2'd2) |=> pin_o);

  // R1: toggle inverts, no action holds
  p_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced && act_i == ACT_TOGGLE) |=> (pin_o != $past(pin_o)));

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced && act_i == ACT_NONE) |=> $stable(pin_o));
endmodule

// File: rtl/pwm_action_qualifier.sv
module pwm_action_qualifier
  import pwm_aq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_zero_i,
  input  logic             ev_period_i,
  input  logic             ev_cmpa_up_i,
  input  logic             ev_cmpb_up_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o
);
  localparam int USED_W = 10;

  aq_ctl_t          ctl_q  [NUM_CH];
  act_e             act_w  [NUM_CH];
  logic             pin_w  [NUM_CH];
  logic [FRC_W-1:0] frc_act;
  aq_ctl_t          ctl_wr;

  assign ctl_wr = {wr_data_i[9:8], wr_data_i[5:4], wr_data_i[3:2], wr_data_i[1:0]};

  generate
    if (REG_W > USED_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_data_i[REG_W-1:USED_W];
    end
  endgenerate

  aq_force_shadow u_frc (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_rld_i   (wr_en_i && wr_addr_i == ADR_RLD),
    .wr_frc_i   (wr_en_i && wr_addr_i == ADR_FRC),
    .rld_data_i (wr_data_i[7:6]),
    .frc_data_i (wr_data_i[FRC_W-1:0]),
    .ev_zero_i  (ev_zero_i),
    .ev_period_i(ev_period_i),
    .frc_act_o  (frc_act)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [1:0] MY_ADR = (ch == 0) ? ADR_CTL_A : ADR_CTL_B;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ctl_q[ch] <= '0;
      else if (wr_en_i && wr_addr_i == MY_ADR)  ctl_q[ch] <= ctl_wr;
    end

    aq_event_pick u_pick (
      .ctl_i      (ctl_q[ch]),
      .ev_zero_i  (ev_zero_i),
      .ev_period_i(ev_period_i),
      .ev_cmpa_i  (ev_cmpa_up_i),
      .ev_cmpb_i  (ev_cmpb_up_i),
      .act_o      (act_w[ch])
    );

    aq_channel_out u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .act_i(act_w[ch]),
      .frc_i(frc_act[2*ch +: 2]),
      .pin_o(pin_w[ch])
    );
  end

  assign pwm_a_o = pin_w[0];
  assign pwm_b_o = pin_w[1];

  // R3: a compare-A hit with a non-zero field decides output A
  p_cmpa_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmpa_up_i && ctl_q[0].on_cmpa == ACT_LOW && frc_act[1:0] != 2'd2)
      |=> !pwm_a_o);
endmodule

// File: tb/pwm_action_qualifier_tb.sv
module pwm_action_qualifier_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_zero = 0, ev_period = 0, ev_cmpa = 0, ev_cmpb = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b;

  int n_vec = 0;
  int n_bad = 0;

  // independent reference state
  logic [9:0] m_ctl [2];
  logic [1:0] m_mode;
  logic [3:0] m_shadow, m_act;
  logic       m_out [2];

  always #10 clk = ~clk;

  pwm_action_qualifier #(.REG_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_zero_i(ev_zero), .ev_period_i(ev_period),
    .ev_cmpa_up_i(ev_cmpa), .ev_cmpb_up_i(ev_cmpb),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
  );

  function automatic logic [1:0] pick(logic [9:0] c, logic [3:0] ev);
    logic [1:0] r = 2'd0;
    if (ev[0] && c[1:0] != 0) r = c[1:0];
    if (ev[1] && c[3:2] != 0) r = c[3:2];
    if (ev[3] && c[9:8] != 0) r = c[9:8];
    if (ev[2] && c[5:4] != 0) r = c[5:4];
    return r;
  endfunction

  function automatic logic next_lvl(logic [1:0] frc, logic [1:0] a, logic cur);
    if (frc == 2'd1) return 1'b0;
    if (frc == 2'd2) return 1'b1;
    case (a)
      2'd1: return 1'b0;
      2'd2: return 1'b1;
      2'd3: return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic check(logic ea, logic eb, string tag);
    n_vec++;
    if (pwm_a !== ea || pwm_b !== eb) begin
      n_bad++;
      $display("FAIL %s: a/b actual %b%b expected %b%b", tag, pwm_a, pwm_b, ea, eb);
    end
  endtask

  // one clock: drive at negedge, step the model, compare at the next negedge
  task automatic cycle(logic [3:0] ev, logic we, logic [1:0] ad, logic [15:0] d, string tag);
    logic [3:0] sh_n;
    logic       ld;
    {ev_cmpb, ev_cmpa, ev_period, ev_zero} = ev;
    wr_en = we; wr_addr = ad; wr_data = d;
    for (int ch = 0; ch < 2; ch++)
      m_out[ch] = next_lvl(m_act[2*ch +: 2], pick(m_ctl[ch], ev), m_out[ch]);
    sh_n = (we && ad == 2'd3) ? d[3:0] : m_shadow;
    ld = (m_mode == 2'd0) ? ev[0] : (m_mode == 2'd1) ? ev[1] :
         (m_mode == 2'd2) ? (ev[0] | ev[1]) : 1'b1;
    if (m_mode == 2'd3) m_act = sh_n;
    else if (ld)        m_act = m_shadow;
    m_shadow = sh_n;
    if (we && ad == 2'd0) m_ctl[0] = d[9:0];
    if (we && ad == 2'd1) m_ctl[1] = d[9:0];
    if (we && ad == 2'd2) m_mode = d[7:6];
    @(negedge clk);
    check(m_out[0], m_out[1], tag);
    {ev_cmpb, ev_cmpa, ev_period, ev_zero} = 4'd0;
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [9:0] cv;
    m_ctl[0] = '0; m_ctl[1] = '0; m_mode = '0; m_shadow = '0; m_act = '0;
    m_out[0] = 1'b0; m_out[1] = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, "R7 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 1'b0, "R7 after reset");
    // R7: all fields zero, so no event may move the pins
    for (int e = 0; e < 16; e++) cycle(4'(e), 1'b0, 2'd0, 16'd0, "R7");

    // R1 R2 R3 R8: every action-field combination against every event pattern
    for (int code = 0; code < 256; code++) begin
      cv = {code[7:6], 2'b00, code[5:0]};
      cycle(4'd0, 1'b1, 2'd0, {6'd0, cv}, "R8");
      cv = ~{code[1:0], 2'b00, code[7:2]};
      cv[7:6] = 2'b00;
      cycle(4'd0, 1'b1, 2'd1, {6'd0, cv}, "R8");
      for (int e = 0; e < 16; e++)
        cycle(4'(e), 1'b0, 2'd0, 16'd0,
              ($countones(4'(e)) > 1) ? "R3" : ((code % 3 == 0) ? "R1" : "R2"));
    end

    // R4 R5 R6: reload points and force codes
    cycle(4'd0, 1'b1, 2'd0, 16'h0333, "R8");
    cycle(4'd0, 1'b1, 2'd1, 16'h0333, "R8");
    for (int md = 0; md < 4; md++) begin
      cycle(4'd0, 1'b1, 2'd2, 16'(md << 6), "R5");
      for (int f = 0; f < 16; f++) begin
        cycle(4'd0, 1'b1, 2'd3, 16'(f), (md == 3) ? "R6" : "R5");
        for (int e = 0; e < 16; e++)
          cycle(4'(e), (e == 5), 2'd3, 16'(15 - f),
                (md == 3) ? "R6" : ((m_act != 0) ? "R4" : "R5"));
      end
    end

    // R9: polarity patterns from a modelled up-counter, expectation by formula
    cycle(4'd0, 1'b1, 2'd2, 16'h00C0, "R6");
    cycle(4'd0, 1'b1, 2'd3, 16'h0000, "R6");
    cycle(4'd0, 1'b1, 2'd0, 16'h001A, "R8");
    cycle(4'd0, 1'b1, 2'd1, 16'h0205, "R8");
    for (int cmp = 1; cmp < 9; cmp++) begin
      for (int rep = 0; rep < 2; rep++) begin
        for (int c = 0; c <= 9; c++) begin
          logic ea;
          {ev_cmpb, ev_cmpa, ev_period, ev_zero} =
            {(c == cmp), (c == cmp), (c == 9), (c == 0)};
          @(negedge clk);
          ea = (c < cmp) || (c == 9);
          check(ea, ~ea, "R9");
        end
      end
    end
    {ev_cmpb, ev_cmpa, ev_period, ev_zero} = 4'd0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule